// File: doc/BRIEF.md
# Remote Reconfiguration Control Register Bank

This block is the register front end of a remote-reconfiguration controller. A host on a word-addressed slave port stores the watchdog timeout, the watchdog enable, the start address of the next configuration image and the image mode. It also reads the cause of the last reconfiguration. The stored values drive the reconfiguration engine directly as sideband outputs.

Two offsets are commands, not storage. Writing a 1 to the kick offset emits a single-cycle watchdog reset pulse. Writing a 1 to the launch offset raises a reconfigure request, which stays high until the engine reports completion on `done_i`.

Read data is registered and appears one cycle after the read strobe. The port never stalls.

Top module: `reconf_csr`

## Requirements
- R1: After reset, every stored field, `kick_o`, `reconfig_o` and `rdata_o` are 0, and `waitreq_o` is 0 at all times.
- R2: Offset 1 holds a 12-bit watchdog timeout from `wdata_i[11:0]`. It drives `wdt_timeout_o` from the cycle after the write and reads back zero-extended.
- R3: Offset 2 holds the watchdog enable from `wdata_i[0]` (1 = enabled). It drives `wdt_en_o` and reads back in bit 0.
- R4: Offset 3 holds the image start address from the low `IMG_ADDR_W` bits of `wdata_i` (24 or 32). Upper write bits are dropped, and the value drives `img_addr_o`.
- R5: Offset 4 holds the image mode from `wdata_i[0]` (1 = application image, 0 = factory image). It drives `app_mode_o`.
- R6: Offset 0 is read-only. Its bits [4:0] return `cause_i` as sampled with the read strobe: bit 4 watchdog expiry, bit 3 external configuration reset, bit 2 logic-requested reconfiguration, bit 1 external status error, bit 0 CRC error. Bits above 4 read 0, and writes to offset 0 change nothing.
- R7: A write to offset 5 with `wdata_i[0]`=1 makes `kick_o` high for exactly the next cycle. With `wdata_i[0]`=0 the write has no effect.
- R8: A write to offset 6 with `wdata_i[0]`=1 raises `reconfig_o` from the next cycle. It stays high until the cycle after `done_i` is sampled high; a new launch in that same cycle wins. A write with bit 0 = 0, or `done_i` while idle, has no effect.
- R9: Offsets 5 and 6 read as 0. Offsets 7 to 15 read as 0, and writes to them change no output.
- R10: `rdata_o` carries the addressed value in the cycle after a read strobe and is 0 after a cycle with no read.
- R11: Writes to offsets 1 to 4 while `reconfig_o` is high are accepted normally and do not drop the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word offset |
| read_i | input | 1 | Read strobe |
| write_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| waitreq_o | output | 1 | Stall indication, tied low |
| cause_i | input | 5 | Reconfiguration cause flags from engine |
| done_i | input | 1 | Engine finished reconfiguration |
| wdt_timeout_o | output | WDT_W | Watchdog timeout value |
| wdt_en_o | output | 1 | Watchdog enable |
| img_addr_o | output | IMG_ADDR_W | Image start address |
| app_mode_o | output | 1 | Image mode (1 = application) |
| kick_o | output | 1 | Watchdog reset pulse |
| reconfig_o | output | 1 | Held reconfigure request |

## Verification
The bench uses the default parameters: a 24-bit image address, a 12-bit timeout, a 32-bit data path and a 4-bit offset. The narrow fields sit under a 32-bit write word, so all-ones writes show that upper bits are truncated on both storage and readback. The 4-bit offset leaves offsets 7 to 15 unmapped, so the bench can probe them with reads and writes.

// File: rtl/reconf_csr_pkg.sv
package reconf_csr_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [3:0] OFS_CAUSE   = 4'd0;
  localparam logic [3:0] OFS_TIMEOUT = 4'd1;
  localparam logic [3:0] OFS_WDT_EN  = 4'd2;
  localparam logic [3:0] OFS_IMG     = 4'd3;
  localparam logic [3:0] OFS_MODE    = 4'd4;
  localparam logic [3:0] OFS_KICK    = 4'd5;
  localparam logic [3:0] OFS_LAUNCH  = 4'd6;

  typedef struct packed {
    logic        wdt_en;
    logic        app_mode;
  } cfg_bits_t;
endpackage

// File: rtl/rcsr_store.sv
module rcsr_store
  import reconf_csr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int WDT_W      = 12,
  parameter int IMG_ADDR_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [WDT_W-1:0]      timeout_o,
  output cfg_bits_t             bits_o,
  output logic [IMG_ADDR_W-1:0] img_o
);
  logic [WDT_W-1:0]      timeout_q;
  logic [IMG_ADDR_W-1:0] img_q;
  cfg_bits_t             bits_q;
  logic                  unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= '0;
      img_q     <= '0;
      bits_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(OFS_TIMEOUT): timeout_q       <= wdata_i[WDT_W-1:0];
        ADDR_W'(OFS_WDT_EN):  bits_q.wdt_en   <= wdata_i[0];
        ADDR_W'(OFS_IMG):     img_q           <= wdata_i[IMG_ADDR_W-1:0];
        ADDR_W'(OFS_MODE):    bits_q.app_mode <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign timeout_o = timeout_q;
  assign img_o     = img_q;
  assign bits_o    = bits_q;

  // R4
  img_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && addr_i == ADDR_W'(OFS_IMG)) |-> $stable(img_q));
endmodule

// File: rtl/rcsr_cmd.sv
module rcsr_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_req_i,
  input  logic launch_req_i,
  input  logic done_i,
  output logic kick_o,
  output logic reconfig_o
);
  logic kick_q, recfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_q  <= 1'b0;
      recfg_q <= 1'b0;
    end else begin
      kick_q <= kick_req_i;
      // a fresh launch wins over a same-cycle done
      if (launch_req_i)  recfg_q <= 1'b1;
      else if (done_i)   recfg_q <= 1'b0;
    end
  end

  assign kick_o     = kick_q;
  assign reconfig_o = recfg_q;

  // R8
  reconfig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recfg_q && !done_i) |=> recfg_q);
endmodule

// File: rtl/rcsr_rdmux.sv
module rcsr_rdmux
  import reconf_csr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int WDT_W      = 12,
  parameter int IMG_ADDR_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  re_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CAUSE_W-1:0]    cause_i,
  input  logic [WDT_W-1:0]      timeout_i,
  input  cfg_bits_t             bits_i,
  input  logic [IMG_ADDR_W-1:0] img_i,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [DATA_W-1:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(OFS_CAUSE):   rd_mux[CAUSE_W-1:0]    = cause_i;
      ADDR_W'(OFS_TIMEOUT): rd_mux[WDT_W-1:0]      = timeout_i;
      ADDR_W'(OFS_WDT_EN):  rd_mux[0]              = bits_i.wdt_en;
      ADDR_W'(OFS_IMG):     rd_mux[IMG_ADDR_W-1:0] = img_i;
      ADDR_W'(OFS_MODE):    rd_mux[0]              = bits_i.app_mode;
      default:              rd_mux                 = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (re_i)  rdata_q <= rd_mux;
    else            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_q == '0);
endmodule

// File: rtl/reconf_csr.sv
module reconf_csr
  import reconf_csr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int WDT_W      = 12,
  parameter int IMG_ADDR_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  read_i,
  input  logic                  write_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  waitreq_o,
  input  logic [4:0]            cause_i,
  input  logic                  done_i,
  output logic [WDT_W-1:0]      wdt_timeout_o,
  output logic                  wdt_en_o,
  output logic [IMG_ADDR_W-1:0] img_addr_o,
  output logic                  app_mode_o,
  output logic                  kick_o,
  output logic                  reconfig_o
);
  cfg_bits_t cfg_bits;
  logic      kick_req, launch_req;

  assign waitreq_o  = 1'b0;
  assign kick_req   = write_i && addr_i == ADDR_W'(OFS_KICK)   && wdata_i[0];
  assign launch_req = write_i && addr_i == ADDR_W'(OFS_LAUNCH) && wdata_i[0];

  rcsr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WDT_W(WDT_W), .IMG_ADDR_W(IMG_ADDR_W)) u_store (
    .clk_i, .rst_ni, .we_i(write_i), .addr_i, .wdata_i,
    .timeout_o(wdt_timeout_o), .bits_o(cfg_bits), .img_o(img_addr_o)
  );

  assign wdt_en_o   = cfg_bits.wdt_en;
  assign app_mode_o = cfg_bits.app_mode;

  rcsr_cmd u_cmd (
    .clk_i, .rst_ni, .kick_req_i(kick_req), .launch_req_i(launch_req),
    .done_i, .kick_o, .reconfig_o
  );

  rcsr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WDT_W(WDT_W), .IMG_ADDR_W(IMG_ADDR_W)) u_rd (
    .clk_i, .rst_ni, .re_i(read_i), .addr_i, .cause_i,
    .timeout_i(wdt_timeout_o), .bits_i(cfg_bits), .img_i(img_addr_o), .rdata_o
  );

  // R7
  kick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> $past(write_i && addr_i == ADDR_W'(OFS_KICK) && wdata_i[0]));
  // R8
  launch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reconfig_o) |-> $past(write_i && addr_i == ADDR_W'(OFS_LAUNCH) && wdata_i[0]));
  // R8
  release_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reconfig_o) |-> $past(done_i));
  // R9
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && addr_i >= ADDR_W'(OFS_KICK)) |=> rdata_o == '0);
  // R1
  no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !waitreq_o);
endmodule

// File: tb/reconf_csr_test.sv
`timescale 1ns/1ps
module reconf_csr_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        read_i = 1'b0, write_i = 1'b0, done_i = 1'b0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        waitreq_o, wdt_en_o, app_mode_o, kick_o, reconfig_o;
  logic [4:0]  cause_i = '0;
  logic [11:0] wdt_timeout_o;
  logic [23:0] img_addr_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  reconf_csr uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; write_i = 1'b1;
    @(negedge clk_i); write_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    @(negedge clk_i); addr_i = a; read_i = 1'b1;
    @(negedge clk_i); read_i = 1'b0; q = rdata_o;
  endtask

  // {tag, is_write, addr, data, expected}
  localparam logic [72:0] VEC [14] = '{
    {4'd2, 1'b1, 4'd1, 32'hFFFF_FABC, 32'h0},
    {4'd2, 1'b0, 4'd1, 32'h0,         32'h0000_0ABC},
    {4'd3, 1'b1, 4'd2, 32'hFFFF_FFFF, 32'h0},
    {4'd3, 1'b0, 4'd2, 32'h0,         32'h0000_0001},
    {4'd4, 1'b1, 4'd3, 32'hDEAD_BEEF, 32'h0},
    {4'd4, 1'b0, 4'd3, 32'h0,         32'h00AD_BEEF},
    {4'd5, 1'b1, 4'd4, 32'h0000_0003, 32'h0},
    {4'd5, 1'b0, 4'd4, 32'h0,         32'h0000_0001},
    {4'd6, 1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0},
    {4'd6, 1'b0, 4'd0, 32'h0,         32'h0000_0015},
    {4'd9, 1'b1, 4'd7, 32'hFFFF_FFFF, 32'h0},
    {4'd9, 1'b0, 4'd7, 32'h0,         32'h0},
    {4'd9, 1'b0, 4'd5, 32'h0,         32'h0},
    {4'd9, 1'b0, 4'd6, 32'h0,         32'h0}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 timeout", 32'(wdt_timeout_o), 0);
    chk("R1 en/mode", {30'd0, wdt_en_o, app_mode_o}, 0);
    chk("R1 img", 32'(img_addr_o), 0);
    chk("R1 cmd", {30'd0, kick_o, reconfig_o}, 0);
    chk("R1 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 waitreq", 32'(waitreq_o), 0);
    rd(4'd1, q); chk("R1 timeout read", q, 0);
    rd(4'd3, q); chk("R1 img read", q, 0);

    cause_i = 5'h15;
    // table walk covers R2 R3 R4 R5 R6 R9
    foreach (VEC[i]) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][67:64], q);
        chk($sformatf("R%0d table row %0d", VEC[i][72:69], i), q, VEC[i][31:0]);
      end
    end
    // R2 R3 R4 R5 outputs; R9 offset 7 write left them intact
    chk("R2 timeout out", 32'(wdt_timeout_o), 32'hABC);
    chk("R3 en out", 32'(wdt_en_o), 1);
    chk("R4 img out", 32'(img_addr_o), 32'hADBEEF);
    chk("R5 mode out", 32'(app_mode_o), 1);
    wr(4'd9, 32'h0);
    chk("R9 unmapped write", {wdt_timeout_o, 2'b0, wdt_en_o, app_mode_o}, {12'hABC, 2'b0, 1'b1, 1'b1});
    wr(4'd4, 32'h0); chk("R5 factory", 32'(app_mode_o), 0);

    // R6 other cause pattern
    cause_i = 5'h0A; rd(4'd0, q); chk("R6 cause", q, 32'h0A);

    // R10 latency and idle zero
    @(negedge clk_i); addr_i = 4'd1; read_i = 1'b1;
    chk("R10 before edge", rdata_o, 0);
    @(negedge clk_i); read_i = 1'b0;
    chk("R10 one cycle", rdata_o, 32'hABC);
    @(negedge clk_i); chk("R10 idle zero", rdata_o, 0);

    // R7 kick pulse
    wr(4'd5, 32'h1); chk("R7 pulse high", 32'(kick_o), 1);
    @(negedge clk_i); chk("R7 pulse ends", 32'(kick_o), 0);
    wr(4'd5, 32'hFFFF_FFFE); chk("R7 zero write", 32'(kick_o), 0);

    // R8 launch / done
    wr(4'd6, 32'h0); chk("R8 zero write", 32'(reconfig_o), 0);
    @(negedge clk_i); done_i = 1'b1;
    @(negedge clk_i); done_i = 1'b0; chk("R8 idle done", 32'(reconfig_o), 0);
    wr(4'd6, 32'h1); chk("R8 raise", 32'(reconfig_o), 1);
    repeat (3) @(negedge clk_i);
    chk("R8 held", 32'(reconfig_o), 1);
    // R11 config writes while pending
    wr(4'd2, 32'h0); chk("R11 en write", 32'(wdt_en_o), 0);
    wr(4'd3, 32'h0012_3456); chk("R11 img write", 32'(img_addr_o), 32'h123456);
    chk("R11 still pending", 32'(reconfig_o), 1);
    @(negedge clk_i); done_i = 1'b1;
    @(negedge clk_i); done_i = 1'b0; chk("R8 release", 32'(reconfig_o), 0);
    // R8 launch wins over same-cycle done
    wr(4'd6, 32'h1);
    @(negedge clk_i); addr_i = 4'd6; wdata_i = 32'h1; write_i = 1'b1; done_i = 1'b1;
    @(negedge clk_i); write_i = 1'b0; done_i = 1'b0;
    chk("R8 launch wins", 32'(reconfig_o), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule